// File: doc/BRIEF.md
# Fault Auto-Restart Sequencer

This block is the supervisory state machine of a resonant converter controller. It takes digital flags from comparators on the soft-start capacitor, the error amplifier, the feedback path and the current sensing. From these it decides when power switching may run, and which soft-start current source is active. At power-up it waits for the supply flag and for a discharged capacitor. It then runs a clamped soft start, which leads into regulation. An overload lets the capacitor rise slowly to a delay flag. An output short or a debounced over-current ends switching at once.

No fault latches the block off. After a trip it releases the clamp and stops switching. It then swings the soft-start capacitor up to its top flag and down to its bottom flag a fixed number of times. Only after the last swing does it go back to the off state, where a valid supply starts a new soft start. The state and the swing count are visible at the ports.

Top module: `ars_sequencer`

## Requirements
- R1: After a synchronous reset the state is OFF, the swing count is 0, the discharge enable is 1 and all other enables are 0. The state port encoding is OFF=0, SOFT=1, RUN=2, OLOAD=3, CHARGE=4, DRAIN=5.
- R2: In OFF only the discharge enable is set. The block moves to SOFT on the first edge where both `supply_ok` and `ss_low` are high. In SOFT, `sw_en`, `ss_chg_en` and `ss_clamp_en` are set.
- R3: SOFT moves to RUN when `ss_run` is high. RUN drives the same enables as SOFT.
- R4: In RUN, `ea_sat` high moves to OLOAD. OLOAD sets `sw_en` and `ss_up_en`, and clears the clamp and the normal charge enable. OLOAD returns to RUN when `ea_sat` falls, and trips to CHARGE when `ss_olp` is high. At most one of the three current-source enables is ever set.
- R5: `short_det` in RUN or OLOAD moves to CHARGE on the next edge. `short_det` has no effect in SOFT.
- R6: An over-current input trips the block (to CHARGE) only after it has been high on OC_DEB_CYC consecutive edges while switching is enabled. A shorter pulse leaves the state unchanged. Each input is filtered on its own.
- R7: CHARGE sets only `ss_up_en`, with switching off. It moves to DRAIN when `ss_top` is high. Fault inputs and `supply_ok` are ignored in CHARGE and in DRAIN.
- R8: DRAIN sets only `ss_dn_en`. When `ss_low` is high it counts one completed swing. If fewer than RESTART_SWINGS swings are complete, it returns to CHARGE with the count raised by one. After the last swing it goes to OFF with the count cleared.
- R9: A low `supply_ok` in SOFT, RUN or OLOAD sends the block to OFF on the next edge, ahead of any fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Hysteretic supply undervoltage flag, high when valid |
| ss_low | input | 1 | Soft-start capacitor at or below its initial level |
| ss_run | input | 1 | Soft-start capacitor has reached the clamp level |
| ss_olp | input | 1 | Soft-start capacitor has reached the overload delay level |
| ss_top | input | 1 | Soft-start capacitor has reached its maximum level |
| ea_sat | input | 1 | Error amplifier output saturated high |
| short_det | input | 1 | Reference minus feedback exceeds the short threshold |
| oc_raw | input | NUM_OC | Raw over-current comparator flags |
| sw_en | output | 1 | Power switching enable |
| ss_chg_en | output | 1 | Normal soft-start charge source enable |
| ss_up_en | output | 1 | Slow charge-up source enable |
| ss_dn_en | output | 1 | Discharge source enable |
| ss_clamp_en | output | 1 | Soft-start clamp enable |
| state | output | 3 | Present sequencer state |
| swing_cnt | output | $clog2(RESTART_SWINGS+1) | Completed restart swings |

## Verification
The bench builds the block with two over-current inputs, a filter depth of 3 and the default four restart swings. A depth of 3 is short enough to place a rejected pulse of two edges next to an accepted one of three edges within a few cycles. It also drives both filter channels, one in each test. Four swings let the bench walk the full count from 0 to 3 and see it clear on the way back to OFF.

// File: rtl/ars_pkg.sv
package ars_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_SOFT   = 3'd1,
    ST_RUN    = 3'd2,
    ST_OLOAD  = 3'd3,
    ST_CHARGE = 3'd4,
    ST_DRAIN  = 3'd5
  } ars_state_e;

  typedef struct packed {
    logic sw;
    logic chg;
    logic up;
    logic dn;
    logic clamp;
  } ars_en_t;

  function automatic ars_en_t decode_en(ars_state_e s);
    ars_en_t e;
    e = '0;
    case (s)
      ST_OFF:    e.dn = 1'b1;
      ST_SOFT,
      ST_RUN:    begin e.sw = 1'b1; e.chg = 1'b1; e.clamp = 1'b1; end
      ST_OLOAD:  begin e.sw = 1'b1; e.up = 1'b1; end
      ST_CHARGE: e.up = 1'b1;
      ST_DRAIN:  e.dn = 1'b1;
      default:   e.dn = 1'b1;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/ars_debounce.sv
module ars_debounce #(
  parameter int DEB_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic raw,
  output logic hit
);
  localparam int CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEB_CYC);

  logic [CW-1:0] run_q;

  // consecutive-edge counter, saturating at LIMIT
  always_ff @(posedge clk) begin
    if (rst || clr || !raw) run_q <= '0;
    else if (run_q != LIMIT) run_q <= run_q + 1'b1;
  end

  assign hit = (run_q == LIMIT);
endmodule

// File: rtl/ars_fsm.sv
module ars_fsm
  import ars_pkg::*;
#(
  parameter int RESTART_SWINGS = 4,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          supply_ok,
  input  logic          ss_low,
  input  logic          ss_run,
  input  logic          ss_olp,
  input  logic          ss_top,
  input  logic          ea_sat,
  input  logic          short_det,
  input  logic          oc_hit,
  output ars_state_e    state_q,
  output ars_en_t       en_q,
  output logic [CW-1:0] cnt_q
);
  localparam logic [CW-1:0] LAST = CW'(RESTART_SWINGS - 1);

  ars_state_e    state_d;
  logic [CW-1:0] cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_OFF: if (supply_ok && ss_low) state_d = ST_SOFT;
      ST_SOFT: begin
        if (!supply_ok)  state_d = ST_OFF;
        else if (oc_hit) state_d = ST_CHARGE;
        else if (ss_run) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (!supply_ok)              state_d = ST_OFF;
        else if (oc_hit || short_det) state_d = ST_CHARGE;
        else if (ea_sat)             state_d = ST_OLOAD;
      end
      ST_OLOAD: begin
        if (!supply_ok)                         state_d = ST_OFF;
        else if (oc_hit || short_det || ss_olp) state_d = ST_CHARGE;
        else if (!ea_sat)                       state_d = ST_RUN;
      end
      ST_CHARGE: if (ss_top) state_d = ST_DRAIN;
      ST_DRAIN: begin
        if (ss_low) begin
          if (cnt_q == LAST) begin
            state_d = ST_OFF;
            cnt_d   = '0;
          end else begin
            state_d = ST_CHARGE;
            cnt_d   = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        state_d = ST_OFF;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      en_q    <= decode_en(ST_OFF);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      en_q    <= decode_en(state_d);
    end
  end
endmodule

// File: rtl/ars_sequencer.sv
module ars_sequencer
  import ars_pkg::*;
#(
  parameter int NUM_OC         = 2,
  parameter int OC_DEB_CYC     = 6,
  parameter int RESTART_SWINGS = 4
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  supply_ok,
  input  logic                                  ss_low,
  input  logic                                  ss_run,
  input  logic                                  ss_olp,
  input  logic                                  ss_top,
  input  logic                                  ea_sat,
  input  logic                                  short_det,
  input  logic [NUM_OC-1:0]                     oc_raw,
  output logic                                  sw_en,
  output logic                                  ss_chg_en,
  output logic                                  ss_up_en,
  output logic                                  ss_dn_en,
  output logic                                  ss_clamp_en,
  output logic [2:0]                            state,
  output logic [$clog2(RESTART_SWINGS+1)-1:0]   swing_cnt
);
  localparam int CW = $clog2(RESTART_SWINGS + 1);

  logic [NUM_OC-1:0] oc_hit;
  ars_state_e        st;
  ars_en_t           en;
  logic [CW-1:0]     cnt;

  // filters are held cleared whenever switching is off
  for (genvar i = 0; i < NUM_OC; i++) begin : g_oc
    ars_debounce #(.DEB_CYC(OC_DEB_CYC)) u_deb (
      .clk (clk),
      .rst (rst),
      .clr (!en.sw),
      .raw (oc_raw[i]),
      .hit (oc_hit[i])
    );
  end

  ars_fsm #(.RESTART_SWINGS(RESTART_SWINGS), .CW(CW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .ss_low    (ss_low),
    .ss_run    (ss_run),
    .ss_olp    (ss_olp),
    .ss_top    (ss_top),
    .ea_sat    (ea_sat),
    .short_det (short_det),
    .oc_hit    (|oc_hit),
    .state_q   (st),
    .en_q      (en),
    .cnt_q     (cnt)
  );

  assign sw_en       = en.sw;
  assign ss_chg_en   = en.chg;
  assign ss_up_en    = en.up;
  assign ss_dn_en    = en.dn;
  assign ss_clamp_en = en.clamp;
  assign state       = st;
  assign swing_cnt   = cnt;
endmodule

// File: rtl/ars_checker.sv
module ars_checker #(
  parameter int NUM_OC         = 2,
  parameter int RESTART_SWINGS = 4
) (
  input logic                                clk,
  input logic                                rst,
  input logic                                supply_ok,
  input logic                                ss_low,
  input logic                                ss_top,
  input logic                                short_det,
  input logic                                sw_en,
  input logic                                ss_chg_en,
  input logic                                ss_up_en,
  input logic                                ss_dn_en,
  input logic [2:0]                          state,
  input logic [$clog2(RESTART_SWINGS+1)-1:0] swing_cnt
);
  localparam int CW = $clog2(RESTART_SWINGS + 1);
  localparam logic [CW-1:0] LAST = CW'(RESTART_SWINGS - 1);

  // R4: current sources never fight each other
  p_one_source_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ss_chg_en, ss_up_en, ss_dn_en}));

  // R5: short in regulation trips at once
  p_short_trip_r5: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd2 && supply_ok && short_det) |=> (state == 3'd4));

  // R7: charge phase holds until the top flag, whatever else happens
  p_charge_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd4 && !ss_top) |=> (state == 3'd4 && !sw_en));

  // R8: a non-final swing raises the count and recharges
  p_swing_step_r8: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd5 && ss_low && swing_cnt != LAST)
      |=> (state == 3'd4 && swing_cnt == CW'($past(swing_cnt) + 1'b1)));

  // R8: the final swing ends in OFF with a cleared count
  p_final_off_r8: assert property (@(posedge clk) disable iff (rst)
    (state == 3'd5 && ss_low && swing_cnt == LAST)
      |=> (state == 3'd0 && swing_cnt == '0));

  // R9: supply loss during operation stops everything
  p_uvlo_r9: assert property (@(posedge clk) disable iff (rst)
    ((state == 3'd1 || state == 3'd2 || state == 3'd3) && !supply_ok)
      |=> (state == 3'd0));
endmodule

bind ars_sequencer ars_checker #(
  .NUM_OC(NUM_OC), .RESTART_SWINGS(RESTART_SWINGS)
) u_chk (.*);

// File: tb/tb_ars_sequencer.sv
module tb_ars_sequencer;
  localparam int NOC = 2;
  localparam int DEB = 3;
  localparam int SW  = 4;
  localparam int CW  = $clog2(SW + 1);
  localparam int NV  = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 0, ss_low = 0, ss_run = 0, ss_olp = 0, ss_top = 0;
  logic ea_sat = 0, short_det = 0;
  logic [NOC-1:0] oc_raw = '0;
  logic sw_en, ss_chg_en, ss_up_en, ss_dn_en, ss_clamp_en;
  logic [2:0] state;
  logic [CW-1:0] swing_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ars_sequencer #(.NUM_OC(NOC), .OC_DEB_CYC(DEB), .RESTART_SWINGS(SW)) dut (.*);

  // inputs {sup,low,run,olp,top,sat,short,oc1,oc0}, expected state, expected count
  localparam logic [14:0] VEC [NV] = '{
    {9'b010000000, 3'd0, 3'd0},  // R9 off without supply
    {9'b100000000, 3'd0, 3'd0},  // R2 needs low cap
    {9'b110000000, 3'd1, 3'd0},  // R2
    {9'b100000100, 3'd1, 3'd0},  // R5 short ignored in SOFT
    {9'b101000000, 3'd2, 3'd0},  // R3
    {9'b100001000, 3'd3, 3'd0},  // R4
    {9'b100000000, 3'd2, 3'd0},  // R4 back to RUN
    {9'b100001000, 3'd3, 3'd0},  // R4
    {9'b100101000, 3'd4, 3'd0},  // R4 overload trip
    {9'b000000111, 3'd4, 3'd0},  // R7 faults, supply ignored
    {9'b000010000, 3'd5, 3'd0},  // R7
    {9'b000000000, 3'd5, 3'd0},  // R8 waits for low
    {9'b010000000, 3'd4, 3'd1},  // R8
    {9'b000010000, 3'd5, 3'd1},
    {9'b010000000, 3'd4, 3'd2},
    {9'b000010000, 3'd5, 3'd2},
    {9'b010000000, 3'd4, 3'd3},
    {9'b000010000, 3'd5, 3'd3},
    {9'b110000000, 3'd0, 3'd0},  // R8 final swing
    {9'b110000000, 3'd1, 3'd0},  // R2 restart
    {9'b101000000, 3'd2, 3'd0},
    {9'b101000100, 3'd4, 3'd0}   // R5 short in RUN
  };

  function automatic logic [4:0] exp_en(logic [2:0] s);
    case (s)
      3'd0, 3'd5: return 5'b00010;
      3'd1, 3'd2: return 5'b11001;
      3'd3:       return 5'b10100;
      3'd4:       return 5'b00100;
      default:    return 5'b00000;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(logic [8:0] v);
    {supply_ok, ss_low, ss_run, ss_olp, ss_top, ea_sat, short_det, oc_raw} = v;
  endtask

  task automatic check(string req, logic [2:0] es, logic [CW-1:0] ec);
    logic [4:0] got;
    got = {sw_en, ss_chg_en, ss_up_en, ss_dn_en, ss_clamp_en};
    n_chk++;
    if (state !== es || swing_cnt !== ec || got !== exp_en(es)) begin
      n_bad++;
      $display("FAIL %s: state=%0d cnt=%0d en=%b expected state=%0d cnt=%0d en=%b",
               req, state, swing_cnt, got, es, ec, exp_en(es));
    end
  endtask

  task automatic to_run();
    rst = 1'b1; drive(9'b110000000); tick(); rst = 1'b0;
    tick();                          // SOFT
    drive(9'b101000000); tick();     // RUN
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    check("R1 reset", 3'd0, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][14:6]);
      tick();
      check($sformatf("R2-9 vector %0d", i), VEC[i][5:3], VEC[i][2:0]);
    end

    // R6: two-edge pulse rejected, three-edge level accepted
    to_run();
    drive(9'b101000001); tick(); tick();
    drive(9'b101000000); tick();
    check("R6 short pulse", 3'd2, '0);
    drive(9'b101000010);
    tick(); tick(); tick();
    check("R6 before accept", 3'd2, '0);
    tick();
    check("R6 accepted", 3'd4, '0);

    // R9: supply loss beats a short in RUN
    to_run();
    drive(9'b001000100); tick();
    check("R9 supply loss", 3'd0, '0);

    // R1: reset in the middle of a restart swing
    to_run();
    drive(9'b101000100); tick();
    rst = 1'b1; tick(); rst = 1'b0;
    check("R1 mid-run reset", 3'd0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule